// File: doc/BRIEF.md
# Status-Steered Command Completion Decider

This block sits beside a descriptor-chain DMA sequencer and settles, for each command that the sequencer reports as finished, three questions: whether to raise an interrupt, whether to hold completion until the device reaches some state, and whether the chain should follow its branch target. Each question has its own selection register. The register holds a 4-bit mask and a 4-bit compare value. These are matched against the channel's 4 device-status bits. A 2-bit mode field in the command word picks one of four policies per question: never, always, act when the masked match holds, or act when it fails.

The sequencer pulses `done_i` with the finished command word on `cmd_i`. When the wait decision is true, completion is held. `wait_o` stays high and the block re-evaluates the wait each cycle, using the latched command word and the live status and selectors. On the first cycle the wait decision is false, the command retires. `retire_o` pulses, `irq_o` pulses if the interrupt decision is true, and `branch_o` takes the branch decision. All three use the same status sample. The selection registers are written through a simple write port.

Top module: `status_cond_eval`

## Requirements
- R1: A write with `sel_we_i` high stores `sel_wdata_i[19:16]` as mask and `sel_wdata_i[3:0]` as compare value into selector `sel_idx_i` (0 interrupt, 1 wait, 2 branch). The new value is used by evaluations from the next cycle on. Index 3 changes no selector.
- R2: The match of a function is true when `(dev_stat_i & mask) == (value & mask)`. After reset all selectors are zero, so every match is true.
- R3: The interrupt mode is `cmd[5:4]`, the branch mode is `cmd[3:2]` and the wait mode is `cmd[1:0]`. Code 0 means never, 1 means act if the match is true, 2 means act if the match is false, and 3 means always.
- R4: `irq_o` is high for exactly the one cycle after a command resolves, and only when its interrupt decision is true.
- R5: If the wait decision is true when a command is evaluated, then from the next cycle `wait_o` is high. While it stays high there is no `irq_o` and no `retire_o`, and `branch_o` does not change. Release happens after the first evaluation whose wait decision is false.
- R6: `branch_o` takes the branch decision when a command resolves and holds that value until the next one resolves.
- R7: `retire_o` pulses once, in the cycle after each command resolves, whether it resolves at `done_i` or at a wait release.
- R8: `done_i` and `cmd_i` are ignored while `wait_o` is high.
- R9: After reset, `irq_o`, `wait_o`, `branch_o` and `retire_o` are all 0.
- R10: At a wait release, the interrupt and branch decisions use the same status sample that released the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_we_i | input | 1 | Selector write strobe |
| sel_idx_i | input | 2 | Selector index: 0 interrupt, 1 wait, 2 branch |
| sel_wdata_i | input | 32 | Selector write data, mask in [19:16], value in [3:0] |
| dev_stat_i | input | 4 | Device status bits of the channel |
| cmd_i | input | 16 | Command word of the command being completed |
| done_i | input | 1 | Command completion strobe |
| irq_o | output | 1 | Interrupt pulse |
| wait_o | output | 1 | Completion held by a wait condition |
| branch_o | output | 1 | Branch taken for the last resolved command |
| retire_o | output | 1 | Command resolved pulse |

## Verification
Directed sequences exercise each mode code against a status that matches and then fails to match the masked compare value. This separates the if-true and if-false policies from never and always, and confirms that a mask bit set to zero hides the corresponding status bit. A wait sequence holds a command while completion strobes keep arriving. The status then changes on the release cycle, which distinguishes the latched command word from the live one and shows that the interrupt and branch decisions use the releasing sample. A long randomized run with frequent selector writes, including to the unused index, is compared every cycle against a behavioural model. That run exposes ordering slips between a selector write and an evaluation in the same cycle.

// File: rtl/sce_pkg.sv
package sce_pkg;
  localparam int STAT_W  = 4;
  localparam int NUM_FN  = 3;
  localparam int FN_INTR = 0;
  localparam int FN_WAIT = 1;
  localparam int FN_BR   = 2;

  typedef enum logic [1:0] {
    MODE_NEVER    = 2'd0,
    MODE_IF_TRUE  = 2'd1,
    MODE_IF_FALSE = 2'd2,
    MODE_ALWAYS   = 2'd3
  } act_mode_e;

  typedef struct packed {
    logic [STAT_W-1:0] mask;
    logic [STAT_W-1:0] value;
  } sel_t;
endpackage

// File: rtl/sce_sel_bank.sv
module sce_sel_bank
  import sce_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MASK_LSB = 16,
  parameter int VAL_LSB  = 0,
  parameter int IDX_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output sel_t              sel_o [NUM_FN]
);
  for (genvar g = 0; g < NUM_FN; g++) begin : g_sel
    sel_t sel_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q <= '0;
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        sel_q.mask  <= wdata_i[MASK_LSB +: STAT_W];
        sel_q.value <= wdata_i[VAL_LSB +: STAT_W];
      end
    end
    assign sel_o[g] = sel_q;
  end
endmodule

// File: rtl/sce_decide.sv
module sce_decide
  import sce_pkg::*;
(
  input  act_mode_e         mode_i,
  input  sel_t              sel_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              act_o
);
  logic hit;
  assign hit = ((stat_i ^ sel_i.value) & sel_i.mask) == '0;

  always_comb begin
    unique case (mode_i)
      MODE_NEVER:    act_o = 1'b0;
      MODE_IF_TRUE:  act_o = hit;
      MODE_IF_FALSE: act_o = ~hit;
      default:       act_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/status_cond_eval.sv
module status_cond_eval
  import sce_pkg::*;
#(
  parameter int CMD_W    = 16,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 2,
  parameter int MASK_LSB = 16,
  parameter int VAL_LSB  = 0,
  parameter int INTR_LSB = 4,
  parameter int BR_LSB   = 2,
  parameter int WAIT_LSB = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_we_i,
  input  logic [IDX_W-1:0]  sel_idx_i,
  input  logic [DATA_W-1:0] sel_wdata_i,
  input  logic [STAT_W-1:0] dev_stat_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              done_i,
  output logic              irq_o,
  output logic              wait_o,
  output logic              branch_o,
  output logic              retire_o
);
  localparam int MODE_W = 2;

  sel_t             sel [NUM_FN];
  logic             hold_q, irq_q, br_q, ret_q;
  logic [CMD_W-1:0] cmd_q, cmd_eff;
  logic             eval;
  act_mode_e        mode [NUM_FN];
  logic [NUM_FN-1:0] act;

  sce_sel_bank #(
    .DATA_W(DATA_W), .MASK_LSB(MASK_LSB), .VAL_LSB(VAL_LSB), .IDX_W(IDX_W)
  ) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(sel_we_i),
    .idx_i(sel_idx_i), .wdata_i(sel_wdata_i), .sel_o(sel)
  );

  // a held command is re-evaluated with its latched word
  assign cmd_eff = hold_q ? cmd_q : cmd_i;
  assign eval    = hold_q | done_i;

  always_comb begin
    mode[FN_INTR] = act_mode_e'(cmd_eff[INTR_LSB +: MODE_W]);
    mode[FN_WAIT] = act_mode_e'(cmd_eff[WAIT_LSB +: MODE_W]);
    mode[FN_BR]   = act_mode_e'(cmd_eff[BR_LSB   +: MODE_W]);
  end

  for (genvar g = 0; g < NUM_FN; g++) begin : g_dec
    sce_decide u_dec (
      .mode_i(mode[g]), .sel_i(sel[g]), .stat_i(dev_stat_i), .act_o(act[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      cmd_q  <= '0;
      irq_q  <= 1'b0;
      br_q   <= 1'b0;
      ret_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      ret_q <= 1'b0;
      if (eval) begin
        hold_q <= act[FN_WAIT];
        cmd_q  <= cmd_eff;
        if (!act[FN_WAIT]) begin
          irq_q <= act[FN_INTR];
          br_q  <= act[FN_BR];
          ret_q <= 1'b1;
        end
      end
    end
  end

  assign irq_o    = irq_q;
  assign wait_o   = hold_q;
  assign branch_o = br_q;
  assign retire_o = ret_q;
endmodule

// File: rtl/sce_checker.sv
module sce_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic done_i,
  input logic irq_o,
  input logic wait_o,
  input logic branch_o,
  input logic retire_o
);
  AST_IRQ_WITH_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> retire_o); // R4
  AST_WAIT_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> (!irq_o && !retire_o)); // R5
  AST_BRANCH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_o |-> $stable(branch_o)); // R6
  AST_RETIRE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |-> $past(done_i || wait_o)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!irq_o && !wait_o && !branch_o && !retire_o)); // R9
endmodule

bind status_cond_eval sce_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_i), .irq_o(irq_o),
  .wait_o(wait_o), .branch_o(branch_o), .retire_o(retire_o)
);

// File: tb/status_cond_eval_tb.sv
module status_cond_eval_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_we_i = 1'b0;
  logic [1:0]  sel_idx_i = '0;
  logic [31:0] sel_wdata_i = '0;
  logic [3:0]  dev_stat_i = '0;
  logic [15:0] cmd_i = '0;
  logic        done_i = 1'b0;
  logic        irq_o, wait_o, branch_o, retire_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  status_cond_eval u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_we_i(sel_we_i), .sel_idx_i(sel_idx_i),
    .sel_wdata_i(sel_wdata_i), .dev_stat_i(dev_stat_i), .cmd_i(cmd_i),
    .done_i(done_i), .irq_o(irq_o), .wait_o(wait_o), .branch_o(branch_o),
    .retire_o(retire_o)
  );

  // behavioural reference model
  int m_mask [3];
  int m_val  [3];
  int m_hold, m_cmd, e_irq, e_br, e_ret;

  function automatic int decide(int md, int fn, int st);
    int hit;
    hit = ((st & m_mask[fn]) == (m_val[fn] & m_mask[fn])) ? 1 : 0;
    if (md == 0) return 0;
    if (md == 3) return 1;
    if (md == 1) return hit;
    return 1 - hit;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 3; i++) begin m_mask[i] = 0; m_val[i] = 0; end
      m_hold = 0; m_cmd = 0; e_irq = 0; e_br = 0; e_ret = 0;
    end else begin
      int c, st, w;
      e_irq = 0; e_ret = 0;
      if (m_hold != 0 || done_i) begin
        c  = (m_hold != 0) ? m_cmd : int'(cmd_i);
        st = int'(dev_stat_i);
        w  = decide((c >> 0) & 3, 1, st);
        m_hold = w; m_cmd = c;
        if (w == 0) begin
          e_irq = decide((c >> 4) & 3, 0, st);
          e_br  = decide((c >> 2) & 3, 2, st);
          e_ret = 1;
        end
      end
      if (sel_we_i && sel_idx_i != 2'd3) begin
        m_mask[sel_idx_i] = int'(sel_wdata_i[19:16]);
        m_val[sel_idx_i]  = int'(sel_wdata_i[3:0]);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      check("R4 irq_o model", int'(irq_o), e_irq);
      check("R5 wait_o model", int'(wait_o), m_hold);
      check("R6 branch_o model", int'(branch_o), e_br);
      check("R7 retire_o model", int'(retire_o), e_ret);
    end
  end

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic wsel(int idx, int mask, int val);
    sel_we_i = 1'b1; sel_idx_i = 2'(idx);
    sel_wdata_i = (32'(mask) << 16) | 32'(val);
    step();
    sel_we_i = 1'b0;
  endtask

  task automatic complete(int cmd, int st);
    cmd_i = 16'(cmd); dev_stat_i = 4'(st); done_i = 1'b1;
    step();
    done_i = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check("R9 irq", int'(irq_o), 0);
    check("R9 wait", int'(wait_o), 0);
    check("R9 branch", int'(branch_o), 0);
    check("R9 retire", int'(retire_o), 0);
    rst_ni = 1'b1;
    step();
    // R2: zero selectors always match; mode 1 interrupt fires
    complete(16'h0010, 4'hA);
    check("R2 reset selector match", int'(irq_o), 1);
    // R1/R2: mask F value 5
    wsel(0, 4'hF, 4'h5);
    complete(16'h0010, 4'h5);
    check("R2 match true irq", int'(irq_o), 1);
    complete(16'h0010, 4'h4);
    check("R2 match false irq", int'(irq_o), 0);
    // R3: if-false mode, never, always
    complete(16'h0020, 4'h4);
    check("R3 if-false irq", int'(irq_o), 1);
    complete(16'h0000, 4'h5);
    check("R3 never irq", int'(irq_o), 0);
    complete(16'h0030, 4'h4);
    check("R3 always irq", int'(irq_o), 1);
    // R2 mask hides bits: mask 1 value 1
    wsel(0, 4'h1, 4'h1);
    complete(16'h0010, 4'hF);
    check("R2 masked match", int'(irq_o), 1);
    // R1 index 3 leaves selectors alone
    wsel(3, 4'hF, 4'h0);
    complete(16'h0010, 4'h1);
    check("R1 index 3 no effect", int'(irq_o), 1);
    // R6 branch if-true, R3 branch field
    wsel(2, 4'hF, 4'h3);
    complete(16'h0004, 4'h3);
    check("R6 branch taken", int'(branch_o), 1);
    step();
    check("R6 branch held", int'(branch_o), 1);
    complete(16'h0004, 4'h2);
    check("R6 branch not taken", int'(branch_o), 0);
    // R5/R8/R10 wait: mask F value 0, hold while status is 0
    wsel(1, 4'hF, 4'h0);
    wsel(0, 4'hF, 4'h6);
    complete(16'h0015, 4'h0);   // intr if-true, branch if-true, wait if-true
    check("R5 wait entered", int'(wait_o), 1);
    check("R5 no retire in wait", int'(retire_o), 0);
    cmd_i = 16'h0000; done_i = 1'b1;   // must be ignored
    step();
    step();
    done_i = 1'b0;
    check("R8 done ignored in wait", int'(retire_o), 0);
    check("R5 still waiting", int'(wait_o), 1);
    dev_stat_i = 4'h6;   // releases wait, matches intr select, not branch (3)
    step();
    check("R7 retire on release", int'(retire_o), 1);
    check("R10 irq uses release status", int'(irq_o), 1);
    check("R10 branch uses release status", int'(branch_o), 0);
    check("R5 wait released", int'(wait_o), 0);
    step();
    check("R4 irq single pulse", int'(irq_o), 0);
    // randomized run against the model
    for (int n = 0; n < 3000; n++) begin
      sel_we_i    = ($urandom_range(0, 5) == 0);
      sel_idx_i   = 2'($urandom_range(0, 3));
      sel_wdata_i = $urandom;
      dev_stat_i  = 4'($urandom);
      cmd_i       = 16'($urandom);
      done_i      = ($urandom_range(0, 1) == 1);
      step();
    end
    sel_we_i = 1'b0; done_i = 1'b0;
    step();
    summary();
  end
endmodule